// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate-Long Unit

This unit takes two 32-bit operands. Each operand packs two signed 16-bit halves. The unit forms two signed 16x16 products, adds both products to a signed 64-bit accumulator, and returns the 64-bit sum as a high word and a low word. The accumulator arrives on two 32-bit inputs. A swap input selects how the halves pair up. In straight pairing, low multiplies low and high multiplies high. In crossed pairing, the second operand is rotated by 16 bits before the multiply, so each low half meets the other operand's high half.

An execute-enable input decides whether the sum is written back. When it is low, the outputs return the incoming accumulator words unchanged. The unit is a two-stage pipeline: the multiplies are in stage one and the three-input 64-bit add is in stage two. A valid/ready handshake sits on each side. When the consumer stalls, the entire pipeline holds. The sum wraps modulo 2^64, and the unit reports no overflow or saturation.

Top module: `dual_half_mac`

## Requirements
- R1: With `swap_pair`=0 and `exec_en`=1, the result equals acc + lo(a)*lo(b) + hi(a)*hi(b). Here lo means bits 15:0, hi means bits 31:16, and acc = {acc_hi, acc_lo}.
- R2: With `swap_pair`=1 and `exec_en`=1, the result equals acc + lo(a)*hi(b) + hi(a)*lo(b).
- R3: Every halfword is treated as two's-complement signed. For example, 0x8000 times 0x8000 gives +2^30.
- R4: The accumulator is the signed 64-bit value {acc_hi, acc_lo}. Each product is sign-extended to 64 bits, and the sum wraps modulo 2^64 with no saturation. Bits 63:32 of the sum appear on `res_hi` and bits 31:0 on `res_lo`.
- R5: With `exec_en`=0, the result equals {acc_hi, acc_lo} unchanged, whatever the operands and `swap_pair`.
- R6: An input is accepted on a clock edge where `in_valid` and `in_ready` are both 1. If `out_ready` is 1 in the cycle after acceptance, the result is presented with `out_valid`=1 exactly two edges after acceptance.
- R7: A synchronous active-high `rst` clears both pipeline valid bits. After reset, `out_valid`=0 and `in_ready`=1.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. On the next edge, `out_valid`, `res_hi` and `res_lo` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid |
| in_ready | output | 1 | Unit can accept an input this cycle |
| op_a | input | 32 | First operand, two signed halves |
| op_b | input | 32 | Second operand, two signed halves |
| acc_hi | input | 32 | Accumulator bits 63:32 |
| acc_lo | input | 32 | Accumulator bits 31:0 |
| swap_pair | input | 1 | 0 selects straight pairing, 1 selects crossed pairing |
| exec_en | input | 1 | 1 writes the sum back, 0 passes the accumulator through |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |

## Verification
The assertions check the following on every cycle:
- the reset clearing of the valid bits;
- the two-edge latency when the output side is draining;
- the frozen output and deasserted `in_ready` under backpressure;
- the exact pass-through of the accumulator for inputs with `exec_en` low.

The arithmetic itself can only be shown by the bench's scenarios. These cover straight and crossed pairing, signed halfword extremes, accumulator wrap at both ends of the 64-bit range, and ordering under random stalls. The bench sweeps every combination of eight boundary halfword values in all four operand halves, with both pairings, and compares each result against an arithmetic model.

// File: rtl/dhm_pkg.sv
package dhm_pkg;
  // Pairing of operand halves for the two multipliers
  typedef enum logic {
    PAIR_STRAIGHT = 1'b0,
    PAIR_CROSSED  = 1'b1
  } pair_mode_e;
endpackage

// File: rtl/dhm_pair_select.sv
module dhm_pair_select #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] b_in,
  input  logic              swap,
  output logic [WORD_W-1:0] b_out
);
  import dhm_pkg::*;

  pair_mode_e mode;
  assign mode = pair_mode_e'(swap);

  // Crossed pairing equals a rotation by one half: lane l takes lane 1-l
  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign b_out[l*HALF_W +: HALF_W] = (mode == PAIR_CROSSED)
                                       ? b_in[(1-l)*HALF_W +: HALF_W]
                                       : b_in[l*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/dhm_mul_stage.sv
module dhm_mul_stage #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int LANES  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          v_in,
  input  logic [WORD_W-1:0]             a,
  input  logic [WORD_W-1:0]             b,
  input  logic [ACC_W-1:0]              acc_in,
  input  logic                          cond_in,
  output logic                          v_out,
  output logic [LANES-1:0][PROD_W-1:0]  prod,
  output logic [ACC_W-1:0]              acc_out,
  output logic                          cond_out
);
  always_ff @(posedge clk) begin
    if (rst)     v_out <= 1'b0;
    else if (en) v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      acc_out  <= acc_in;
      cond_out <= cond_in;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    logic signed [PROD_W-1:0] ax, bx;
    assign ax = {{(PROD_W-HALF_W){a[l*HALF_W+HALF_W-1]}}, a[l*HALF_W +: HALF_W]};
    assign bx = {{(PROD_W-HALF_W){b[l*HALF_W+HALF_W-1]}}, b[l*HALF_W +: HALF_W]};
    always_ff @(posedge clk) begin
      if (en) prod[l] <= ax * bx;
    end
  end
endmodule

// File: rtl/dhm_sum_stage.sv
module dhm_sum_stage #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int EXT_W  = ACC_W - PROD_W,
  localparam int LANES  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          v_in,
  input  logic [LANES-1:0][PROD_W-1:0]  prod,
  input  logic [ACC_W-1:0]              acc,
  input  logic                          cond,
  output logic                          v_out,
  output logic [ACC_W-1:0]              res
);
  logic [ACC_W-1:0] sum;

  // Sign-extend each product and add with modulo-2^ACC_W wrap
  always_comb begin
    sum = acc;
    for (int l = 0; l < LANES; l++) begin
      sum = sum + {{EXT_W{prod[l][PROD_W-1]}}, prod[l]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     v_out <= 1'b0;
    else if (en) v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) res <= cond ? sum : acc;
  end
endmodule

// File: rtl/dual_half_mac.sv
module dual_half_mac #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  input  logic              swap_pair,
  input  logic              exec_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo
);
  logic                         advance;
  logic [WORD_W-1:0]            b_aligned;
  logic                         s1_valid;
  logic [LANES-1:0][PROD_W-1:0] s1_prod;
  logic [ACC_W-1:0]             s1_acc;
  logic                         s1_cond;
  logic [ACC_W-1:0]             s2_res;

  // Whole pipeline moves only when the output register can be refilled
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  dhm_pair_select #(.HALF_W(HALF_W)) pair_i (
    .b_in  (op_b),
    .swap  (swap_pair),
    .b_out (b_aligned)
  );

  dhm_mul_stage #(.HALF_W(HALF_W)) mul_i (
    .clk      (clk),
    .rst      (rst),
    .en       (advance),
    .v_in     (in_valid),
    .a        (op_a),
    .b        (b_aligned),
    .acc_in   ({acc_hi, acc_lo}),
    .cond_in  (exec_en),
    .v_out    (s1_valid),
    .prod     (s1_prod),
    .acc_out  (s1_acc),
    .cond_out (s1_cond)
  );

  dhm_sum_stage #(.HALF_W(HALF_W)) sum_i (
    .clk   (clk),
    .rst   (rst),
    .en    (advance),
    .v_in  (s1_valid),
    .prod  (s1_prod),
    .acc   (s1_acc),
    .cond  (s1_cond),
    .v_out (out_valid),
    .res   (s2_res)
  );

  assign res_hi = s2_res[ACC_W-1:WORD_W];
  assign res_lo = s2_res[WORD_W-1:0];
endmodule

// File: rtl/dual_half_mac_chk.sv
module dual_half_mac_chk #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] acc_hi,
  input logic [WORD_W-1:0] acc_lo,
  input logic              exec_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] res_hi,
  input logic [WORD_W-1:0] res_lo
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready)); // R7

  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 out_ready |=> out_valid); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_hi) && $stable(res_lo))); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_DISABLED_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !exec_en) ##1 out_ready
    |=> (out_valid && ({res_hi, res_lo} == $past({acc_hi, acc_lo}, 2)))); // R5
endmodule

bind dual_half_mac dual_half_mac_chk #(.HALF_W(HALF_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .acc_hi    (acc_hi),
  .acc_lo    (acc_lo),
  .exec_en   (exec_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res_hi    (res_hi),
  .res_lo    (res_lo)
);

// File: tb/dual_half_mac_tb_top.sv
module dual_half_mac_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0, acc_hi = '0, acc_lo = '0;
  logic        swap_pair = 1'b0, exec_en = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res_hi, res_lo;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_half_mac dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .swap_pair(swap_pair), .exec_en(exec_en), .out_valid(out_valid),
    .out_ready(out_ready), .res_hi(res_hi), .res_lo(res_lo)
  );

  function automatic logic [63:0] ref_mac(input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc, input logic sw,
                                          input logic cd);
    logic [31:0] bb;
    longint p0, p1;
    if (!cd) return acc;
    bb = sw ? {b[15:0], b[31:16]} : b;
    p0 = longint'($signed(a[15:0]))  * longint'($signed(bb[15:0]));
    p1 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
    return acc + 64'(p0) + 64'(p1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; books what the next rising edge does
  task automatic step(output bit accepted);
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R6", {res_hi, res_lo}, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_hi, res_lo} == e, t, {res_hi, res_lo}, e);
      end
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(ref_mac(op_a, op_b, {acc_hi, acc_lo}, swap_pair, exec_en));
      tag_q.push_back(!exec_en ? "R5" : (swap_pair ? "R2" : "R1"));
    end
    @(negedge clk);
  endtask

  // Send one vector; out_ready follows the random stall pattern when stall is set
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                      input logic sw, input logic cd, input bit stall, input string tag,
                      input logic [63:0] hand_exp, input bit use_hand);
    bit acc_ok;
    op_a = a; op_b = b; {acc_hi, acc_lo} = acc; swap_pair = sw; exec_en = cd;
    in_valid = 1'b1;
    do begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
      step(acc_ok);
    end while (!acc_ok);
    if (use_hand) begin
      // Hand-computed value replaces the model value for directed corners
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
      exp_q.push_back(hand_exp);
      tag_q.push_back(tag);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit dummy;
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 8 && (exp_q.size() != 0 || out_valid); k++) step(dummy);
    check(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] vals [8];
    logic [63:0] accs [4];
    logic [63:0] held;
    bit dummy;
    vals = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF, 16'h1234, 16'hC3A5};
    accs = '{64'h0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};

    // R7: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7", 64'(out_valid), 64'h0);
    check(in_ready == 1'b1, "R7", 64'(in_ready), 64'h1);
    @(negedge clk);

    // Directed corners with hand-computed results
    send(32'h8000_8000, 32'h8000_8000, 64'h0, 1'b0, 1'b1, 1'b0, "R3", 64'h0000_0000_8000_0000, 1'b1);
    send(32'h8000_8000, 32'h8000_8000, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0, "R4", 64'h8000_0000_8000_0000, 1'b1);
    send(32'h8000_8000, 32'h8000_8000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, "R4", 64'h8000_0000_7FFF_FFFF, 1'b1);
    send(32'hFFFF_FFFF, 32'h0001_0002, 64'h0, 1'b0, 1'b1, 1'b0, "R3", 64'hFFFF_FFFF_FFFF_FFFD, 1'b1);
    send(32'h0002_0003, 32'h0005_0007, 64'd10, 1'b0, 1'b1, 1'b0, "R1", 64'd41, 1'b1);
    send(32'h0002_0003, 32'h0005_0007, 64'd10, 1'b1, 1'b1, 1'b0, "R2", 64'd39, 1'b1);
    send(32'h8000_8000, 32'h7FFF_8000, 64'h1122_3344_5566_7788, 1'b1, 1'b0, 1'b0, "R5", 64'h1122_3344_5566_7788, 1'b1);
    drain();

    // R6: exact two-edge latency
    op_a = 32'h0003_0004; op_b = 32'h0005_0006; {acc_hi, acc_lo} = 64'd1;
    swap_pair = 1'b0; exec_en = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    step(dummy);
    in_valid = 1'b0;
    #1 check(out_valid == 1'b0, "R6", 64'(out_valid), 64'h0);
    step(dummy);
    #1 check(out_valid == 1'b1, "R6", 64'(out_valid), 64'h1);
    check({res_hi, res_lo} == 64'd40, "R6", {res_hi, res_lo}, 64'd40);
    drain();

    // R8: backpressure holds output and blocks input
    out_ready = 1'b0;
    op_a = 32'h1111_2222; op_b = 32'h3333_4444; {acc_hi, acc_lo} = 64'h5;
    swap_pair = 1'b0; exec_en = 1'b1; in_valid = 1'b1;
    step(dummy);
    op_a = 32'h7FFF_8000;
    step(dummy);
    op_a = 32'h0101_0202;
    #1;
    check(out_valid == 1'b1, "R8", 64'(out_valid), 64'h1);
    held = {res_hi, res_lo};
    for (int k = 0; k < 3; k++) begin
      step(dummy);
      #1;
      check(in_ready == 1'b0, "R8", 64'(in_ready), 64'h0);
      check(out_valid == 1'b1 && {res_hi, res_lo} == held, "R8", {res_hi, res_lo}, held);
    end
    in_valid = 1'b0;
    drain();

    // Sweep: all combinations of boundary halves, both pairings, random stalls
    for (int idx = 0; idx < 8192; idx++) begin
      logic [31:0] a, b;
      a = {vals[(idx >> 3) & 7], vals[idx & 7]};
      b = {vals[(idx >> 9) & 7], vals[(idx >> 6) & 7]};
      send(a, b, accs[(idx * 7) & 3] ^ 64'(idx), idx[12], (idx % 11) != 0, 1'b1, "", 64'h0, 1'b0);
    end
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule